// File: doc/BRIEF.md
# Narrow Load/Store Lane Aligner

This block sits between a processor core and a data memory organised in 32-bit words. It lets the core perform byte, halfword and word accesses against that memory. For loads it picks the addressed byte or halfword out of the word returned by memory and widens it to a full register value. The widening is either sign-preserving or zero-filling, chosen by a flag. For stores it copies the low byte or low halfword of the source register into every lane where it could land. It also produces a per-byte write mask, so that memory updates only the addressed lane or lanes.

Lanes are numbered big-endian: the lowest address offset names the most significant byte of the word. An access whose offset does not suit its size is flagged as misaligned. Such an access yields an empty write mask and a zero load result. All outputs are registered, so each result appears one clock after its inputs are presented. A new access may be presented on every cycle.

Top module: `ls_lane_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs (`ld_result`, `st_word`, `st_be`, `misalign`) become zero on that edge.
- R2: Outputs are registered: the result for the inputs present at a rising edge appears after that edge, and inputs may change every cycle, each giving its own result.
- R3: Lanes are big-endian. A byte access at offset k (`addr_lo`) uses bits 31-8k down to 24-8k. A halfword access at offset 0 uses bits 31:16, and one at offset 2 uses bits 15:0.
- R4: A byte load (`acc_size` = 2'b00) with `acc_unsigned` = 0 returns the selected byte in bits 7:0, with bit 7 copied into bits 31:8.
- R5: A halfword load (`acc_size` = 2'b01) with `acc_unsigned` = 0 returns the selected halfword in bits 15:0, with bit 15 copied into bits 31:16.
- R6: With `acc_unsigned` = 1, byte and halfword loads return the selected field with all upper bits zero.
- R7: A byte store places bits 7:0 of `st_reg` in all four lanes of `st_word`. It sets exactly one bit of `st_be`, where bit i covers bits 8i+7:8i, so offset 0 gives 4'b1000 and offset 3 gives 4'b0001.
- R8: A halfword store places bits 15:0 of `st_reg` in both halves of `st_word`. It gives `st_be` = 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R9: A word access (`acc_size` = 2'b10) at offset 0 returns `rd_word` unchanged, passes `st_reg` unchanged and gives `st_be` = 4'b1111. `acc_unsigned` has no effect on it.
- R10: Some accesses are misaligned: a halfword with `addr_lo[0]` = 1, a word with a nonzero offset, or the reserved size 2'b11. For these, `misalign` = 1, `st_be` = 4'b0000 and `ld_result` = 0. Otherwise `misalign` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| acc_unsigned | input | 1 | 1 selects zero-filling of narrow loads |
| addr_lo | input | 2 | Byte offset of the access within the word |
| rd_word | input | 32 | Word read from memory |
| st_reg | input | 32 | Source register value for stores |
| ld_result | output | 32 | Aligned and widened load value |
| st_word | output | 32 | Store data with the source replicated into lanes |
| st_be | output | 4 | Byte write enables, bit i covers bits 8i+7:8i |
| misalign | output | 1 | Offset does not suit the access size |

## Verification
The assertions watch, on every cycle, the properties that hold for any data. These are the extension bits of narrow loads, the zero upper bits of zero-filled loads, and the single-lane mask with the low-byte copy for byte stores. They also cover word pass-through and the empty mask on misaligned offsets. Only the bench's scenarios can show that the correct lane is picked for each offset in big-endian order. The same holds for the exact mask pattern per halfword offset, and for back-to-back accesses each giving their own result one cycle later.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_lane_decode.sv
module lsa_lane_decode
  import lsa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic [LANES-1:0] lane_mask,
  output logic             bad_align
);
  // Lane i holds bits i*LANE_W upward; offset 0 is the top lane.
  logic [LANES-1:0] byte_hit;
  logic [LANES-1:0] half_hit;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      byte_hit[i] = (int'(ofs) == (LANES - 1 - i));
      half_hit[i] = ((int'(ofs) / 2) == ((LANES - 1 - i) / 2));
    end
  end

  always_comb begin
    bad_align = 1'b0;
    lane_mask = '0;
    unique case (size)
      ACC_BYTE: lane_mask = byte_hit;
      ACC_HALF: begin
        bad_align = ofs[0];
        lane_mask = ofs[0] ? '0 : half_hit;
      end
      ACC_WORD: begin
        bad_align = |ofs;
        lane_mask = (|ofs) ? '0 : '1;
      end
      default:  bad_align = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int HALVES = LANES / 2,
  localparam int HALF_W = 2 * LANE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic              is_unsigned,
  input  logic              bad_align,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ld_data
);
  logic [LANE_W-1:0] sel_b;
  logic [HALF_W-1:0] sel_h;
  logic              fill_b;
  logic              fill_h;

  always_comb begin
    sel_b = '0;
    for (int i = 0; i < LANES; i++)
      if (int'(ofs) == i) sel_b = rd_word[DATA_W-1-i*LANE_W -: LANE_W];
  end

  always_comb begin
    sel_h = '0;
    for (int h = 0; h < HALVES; h++)
      if ((int'(ofs) / 2) == h) sel_h = rd_word[DATA_W-1-h*HALF_W -: HALF_W];
  end

  assign fill_b = sel_b[LANE_W-1] & ~is_unsigned;
  assign fill_h = sel_h[HALF_W-1] & ~is_unsigned;

  always_comb begin
    ld_data = '0;
    if (!bad_align) begin
      unique case (size)
        ACC_BYTE: ld_data = {{(DATA_W-LANE_W){fill_b}}, sel_b};
        ACC_HALF: ld_data = {{(DATA_W-HALF_W){fill_h}}, sel_h};
        ACC_WORD: ld_data = rd_word;
        default:  ld_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsa_store_place.sv
module lsa_store_place
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] st_reg,
  output logic [DATA_W-1:0] st_data
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] from_byte;
    logic [LANE_W-1:0] from_half;
    logic [LANE_W-1:0] from_word;
    assign from_byte = st_reg[LANE_W-1:0];
    assign from_half = st_reg[(k % 2)*LANE_W +: LANE_W];
    assign from_word = st_reg[k*LANE_W +: LANE_W];
    always_comb begin
      unique case (size)
        ACC_BYTE: st_data[k*LANE_W +: LANE_W] = from_byte;
        ACC_HALF: st_data[k*LANE_W +: LANE_W] = from_half;
        default:  st_data[k*LANE_W +: LANE_W] = from_word;
      endcase
    end
  end
endmodule

// File: rtl/ls_lane_aligner.sv
module ls_lane_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int HALF_W = 2 * LANE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_size,
  input  logic              acc_unsigned,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] st_reg,
  output logic [DATA_W-1:0] ld_result,
  output logic [DATA_W-1:0] st_word,
  output logic [LANES-1:0]  st_be,
  output logic              misalign
);
  acc_size_e         size;
  logic [LANES-1:0]  mask_c;
  logic              bad_c;
  logic [DATA_W-1:0] ld_c;
  logic [DATA_W-1:0] st_c;

  assign size = acc_size_e'(acc_size);

  lsa_lane_decode #(.LANES(LANES)) u_dec (
    .size(size), .ofs(addr_lo), .lane_mask(mask_c), .bad_align(bad_c)
  );

  lsa_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
    .size(size), .is_unsigned(acc_unsigned), .bad_align(bad_c),
    .ofs(addr_lo), .rd_word(rd_word), .ld_data(ld_c)
  );

  lsa_store_place #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
    .size(size), .st_reg(st_reg), .st_data(st_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_result <= '0;
      st_word   <= '0;
      st_be     <= '0;
      misalign  <= 1'b0;
    end else begin
      ld_result <= ld_c;
      st_word   <= st_c;
      st_be     <= mask_c;
      misalign  <= bad_c;
    end
  end

  // Assertions
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ld_result == '0 && st_be == '0 && !misalign));

  assert_byte_sext_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b00 && !acc_unsigned) |=>
      (ld_result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){ld_result[LANE_W-1]}}));

  assert_half_sext_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b01 && !addr_lo[0] && !acc_unsigned) |=>
      (ld_result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){ld_result[HALF_W-1]}}));

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b00 && acc_unsigned) |=> (ld_result[DATA_W-1:LANE_W] == '0));

  assert_byte_store_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b00) |=>
      ($countones(st_be) == 1 && st_word[LANE_W-1:0] == $past(st_reg[LANE_W-1:0])
       && st_word[DATA_W-1 -: LANE_W] == $past(st_reg[LANE_W-1:0])));

  assert_half_store_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b01 && !addr_lo[0]) |=>
      ($countones(st_be) == 2 && st_word[DATA_W-1 -: HALF_W] == $past(st_reg[HALF_W-1:0])));

  assert_word_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_size == 2'b10 && addr_lo == '0) |=>
      (ld_result == $past(rd_word) && st_word == $past(st_reg) && st_be == '1 && !misalign));

  assert_misalign_R10: assert property (@(posedge clk) disable iff (rst)
    ((acc_size == 2'b01 && addr_lo[0]) || (acc_size == 2'b10 && addr_lo != '0)
      || acc_size == 2'b11) |=> (misalign && st_be == '0 && ld_result == '0));
endmodule

// File: tb/sim_ls_lane_aligner.sv
`timescale 1ns/1ps
module sim_ls_lane_aligner;
  typedef struct {
    logic [31:0] ld;
    logic [31:0] sw;
    logic [3:0]  be;
    logic        mis;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_size = 2'b10;
  logic        acc_unsigned = 1'b0;
  logic [1:0]  addr_lo = 2'b00;
  logic [31:0] rd_word = 32'hFFFF_FFFF;
  logic [31:0] st_reg = 32'hFFFF_FFFF;
  logic [31:0] ld_result;
  logic [31:0] st_word;
  logic [3:0]  st_be;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  ls_lane_aligner u0 (
    .clk(clk), .rst(rst), .acc_size(acc_size), .acc_unsigned(acc_unsigned),
    .addr_lo(addr_lo), .rd_word(rd_word), .st_reg(st_reg),
    .ld_result(ld_result), .st_word(st_word), .st_be(st_be), .misalign(misalign)
  );

  function automatic exp_t model(input logic [1:0] sz, input logic u,
                                 input logic [1:0] o, input logic [31:0] rd,
                                 input logic [31:0] st, input string tag);
    exp_t e;
    logic [31:0] b, h;
    b = (rd >> (8 * (3 - o))) & 32'hFF;
    h = (rd >> (16 * (1 - o / 2))) & 32'hFFFF;
    e.tag = tag;
    e.mis = (sz == 2'b11) || (sz == 2'b01 && o[0]) || (sz == 2'b10 && o != 0);
    e.ld = 0;
    e.be = 0;
    case (sz)
      2'b00: begin
        e.sw = {4{st[7:0]}};
        e.be = 4'b1000 >> o;
        e.ld = (u || !b[7]) ? b : (b | 32'hFFFF_FF00);
      end
      2'b01: begin
        e.sw = {2{st[15:0]}};
        e.be = (o == 0) ? 4'b1100 : 4'b0011;
        e.ld = (u || !h[15]) ? h : (h | 32'hFFFF_0000);
      end
      default: begin
        e.sw = st;
        e.be = 4'b1111;
        e.ld = rd;
      end
    endcase
    if (e.mis) begin
      e.ld = 0;
      e.be = 0;
    end
    return e;
  endfunction

  task automatic drive(input logic [1:0] sz, input logic u, input logic [1:0] o,
                       input logic [31:0] rd, input logic [31:0] st, input string tag);
    @(negedge clk);
    acc_size = sz; acc_unsigned = u; addr_lo = o; rd_word = rd; st_reg = st;
    q.push_back(model(sz, u, o, rd, st, tag));
  endtask

  // Monitor: compares each registered result one edge after its inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ld_result !== e.ld || st_word !== e.sw || st_be !== e.be || misalign !== e.mis) begin
          errors++;
          $display("FAIL %s: ld=%h/%h sw=%h/%h be=%b/%b mis=%b/%b (actual/expected)",
                   e.tag, ld_result, e.ld, st_word, e.sw, st_be, e.be, misalign, e.mis);
        end
      end
    end
  end

  initial begin
    logic [31:0] rda, sta;
    rda = 32'h81F2_7A05;
    sta = 32'hC3B4_96E7;
    // R1: reset clears outputs although inputs describe a word access
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (ld_result !== 0 || st_word !== 0 || st_be !== 0 || misalign !== 0) begin
      errors++;
      $display("FAIL R1: ld=%h sw=%h be=%b mis=%b expected all zero",
               ld_result, st_word, st_be, misalign);
    end
    @(negedge clk);
    rst = 1'b0;
    // R3/R4/R7: signed byte loads and byte stores at every offset, back to back (R2)
    for (int o = 0; o < 4; o++) drive(2'b00, 1'b0, 2'(o), rda, sta, "R3_R4_R7_R2");
    // R6: unsigned byte loads
    for (int o = 0; o < 4; o++) drive(2'b00, 1'b1, 2'(o), rda, sta, "R6");
    // R4: positive bytes do not extend with ones
    for (int o = 0; o < 4; o++) drive(2'b00, 1'b0, 2'(o), 32'h7F01_7E00, 32'h0000_005A, "R4");
    // R5/R8: signed halfword loads and halfword stores
    drive(2'b01, 1'b0, 2'd0, rda, sta, "R5_R8");
    drive(2'b01, 1'b0, 2'd2, rda, sta, "R5_R8");
    drive(2'b01, 1'b0, 2'd2, 32'h1234_F00D, sta, "R5");
    // R6: unsigned halfword loads
    drive(2'b01, 1'b1, 2'd0, rda, sta, "R6");
    drive(2'b01, 1'b1, 2'd2, 32'h1234_F00D, sta, "R6");
    // R9: word access, unsigned flag irrelevant
    drive(2'b10, 1'b0, 2'd0, rda, sta, "R9");
    drive(2'b10, 1'b1, 2'd0, rda, sta, "R9");
    // R10: misaligned offsets and reserved size
    drive(2'b01, 1'b0, 2'd1, rda, sta, "R10");
    drive(2'b01, 1'b1, 2'd3, rda, sta, "R10");
    for (int o = 1; o < 4; o++) drive(2'b10, 1'b0, 2'(o), rda, sta, "R10");
    drive(2'b11, 1'b0, 2'd0, rda, sta, "R10");
    // R2: aligned access right after a misaligned one
    drive(2'b00, 1'b1, 2'd3, rda, sta, "R2");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule